// File: doc/BRIEF.md
# Multi-Class Register Rename Table

This block keeps the architectural-to-physical register mapping for an out-of-order core. Three register classes are renamed: integer, floating-point and condition-code. Each has its own mapping table and its own pool of free physical tags. A fourth class, misc, is never renamed. Each misc architectural register keeps a fixed physical tag for the whole run. One integer register is a hardwired zero register and is never given a new tag.

The rename port takes a class code and an architectural index. In the same cycle it returns the tag about to be assigned and the tag it displaces. The displaced tag goes back later through the release port, once the rest of the pipeline decides it is dead. The lookup port reads the current mapping combinationally. The restore port writes one mapping back, as a commit or a squash does, and checks that the supplied tag belongs to the class it is written to. The number of free tags in each renamed class is visible on the outputs at all times.

A physical tag is `TW = 2 + log2(PHYS_N)` bits wide. Its top two bits hold the class code and its low bits hold the index within that class. Class codes are: 0 integer, 1 floating-point, 2 condition-code, 3 misc. Codes 4 to 7 are unknown.

Top module: `rmap_top`

## Requirements
- R1: After reset, architectural register i of each renamed class maps to tag {class, i}. Each free pool holds indices ARCH_N to PHYS_N-1 in ascending order, and each free count reads PHYS_N-ARCH_N.
- R2: A rename of a renamed class with a non-empty pool returns the pool head as the new tag {class, head} and the current mapping as the previous tag. At the next clock edge the entry holds the head index and the count drops by one, unless a release of the same class happens in the same cycle.
- R3: A rename with class 3 (misc) returns {3, index} as both the new and the previous tag and takes nothing from any pool.
- R4: A lookup with class 3 returns {3, index} without reading any table.
- R5: A restore with class 3 changes no state. It raises the restore error exactly when the tag differs from {3, index}.
- R6: A restore to class 0, 1 or 2 whose tag class bits differ from the class raises the restore error and leaves the map unchanged. A matching restore writes the tag index at the next edge.
- R7: Class codes 4 to 7 raise the error output of the port that uses them (rename and restore only when their valid is high; lookup always). They change no state and return a tag of zero.
- R8: Integer register ZERO_IDX (0 by default) is never renamed. A rename of it returns its current mapping as both tags and allocates nothing. A restore to it writes nothing.
- R9: When the pool of the requested renamed class is empty, ren_ready is low and the rename changes no state. This test comes before the zero-register handling. For class 3 and unknown codes, ren_ready is high.
- R10: A release pushes the low tag bits onto the tail of the pool named by the tag class bits, which raises that count by one. A release with tag class 3 is ignored.
- R11: When a rename and a restore write the same entry in the same cycle, the restore value is kept. The rename still consumes its pool head.
- R12: Lookup is combinational and shows the state after the last clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename request |
| ren_class | input | 3 | Rename class code |
| ren_arch | input | AW | Rename architectural index |
| ren_ready | output | 1 | Rename can be accepted this cycle |
| ren_new_tag | output | TW | Tag assigned by the rename |
| ren_prev_tag | output | TW | Tag displaced by the rename |
| ren_err | output | 1 | Unknown class on rename |
| lk_class | input | 3 | Lookup class code |
| lk_arch | input | AW | Lookup architectural index |
| lk_tag | output | TW | Current mapping |
| lk_err | output | 1 | Unknown class on lookup |
| set_valid | input | 1 | Restore request |
| set_class | input | 3 | Restore class code |
| set_arch | input | AW | Restore architectural index |
| set_tag | input | TW | Tag to restore |
| set_err | output | 1 | Restore class or misc mismatch |
| rel_valid | input | 1 | Return a tag to its pool |
| rel_tag | input | TW | Tag returned |
| free_cnt_int | output | CW | Free integer tags |
| free_cnt_fp | output | CW | Free floating-point tags |
| free_cnt_cc | output | CW | Free condition-code tags |

## Verification
A rename and a restore can hit the same map entry, or two different entries of one class, in the same cycle. The bench forces the same-entry case directly and lets the random phase produce both cases. It judges the outcome through a lookup on the following cycle, against a model that applies the rename write first and the restore write second. A rename and a release can also meet in one pool in the same cycle. The model checks that the free count stays level and that the released index ends up behind all earlier free tags.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
  typedef enum logic [2:0] {
    RC_INT  = 3'd0,
    RC_FP   = 3'd1,
    RC_CC   = 3'd2,
    RC_MISC = 3'd3
  } reg_class_e;

  localparam int unsigned N_RENAMED = 3;
endpackage

// File: rtl/rmap_freelist.sv
module rmap_freelist #(
  parameter int ARCH_N = 8,
  parameter int PHYS_N = 16,
  parameter int PW     = 4,
  parameter int CW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push,
  input  logic [PW-1:0] push_idx,
  output logic [PW-1:0] head_idx,
  output logic [CW-1:0] count
);
  localparam int INIT = PHYS_N - ARCH_N;

  logic [PW-1:0] slot_q [PHYS_N];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(PHYS_N - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rd_d  = pop  ? bump(rd_q) : rd_q;
    wr_d  = push ? bump(wr_q) : wr_q;
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PHYS_N; i++)
        slot_q[i] <= (i < INIT) ? PW'(ARCH_N + i) : '0;
      rd_q  <= '0;
      wr_q  <= PW'(INIT % PHYS_N);
      cnt_q <= CW'(INIT);
    end else begin
      if (push) slot_q[wr_q] <= push_idx;
      if (pop)  rd_q <= rd_d;
      if (push) wr_q <= wr_d;
      if (push != pop) cnt_q <= cnt_d;
    end
  end

  assign head_idx = slot_q[rd_q];
  assign count    = cnt_q;
endmodule

// File: rtl/rmap_map_table.sv
module rmap_map_table #(
  parameter int ARCH_N = 8,
  parameter int AW     = 3,
  parameter int PW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wa_en,
  input  logic [AW-1:0] wa_arch,
  input  logic [PW-1:0] wa_idx,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_arch,
  input  logic [PW-1:0] wb_idx,
  input  logic [AW-1:0] ra_arch,
  output logic [PW-1:0] ra_idx,
  input  logic [AW-1:0] rb_arch,
  output logic [PW-1:0] rb_idx
);
  logic [PW-1:0] map_q [ARCH_N];
  logic [PW-1:0] map_d [ARCH_N];

  // port b (restore) is applied last so it wins on a shared entry
  always_comb begin
    map_d = map_q;
    if (wa_en) map_d[wa_arch] = wa_idx;
    if (wb_en) map_d[wb_arch] = wb_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_N; i++) map_q[i] <= PW'(i);
    end else if (wa_en || wb_en) begin
      map_q <= map_d;
    end
  end

  assign ra_idx = map_q[ra_arch];
  assign rb_idx = map_q[rb_arch];
endmodule

// File: rtl/rmap_top.sv
module rmap_top
  import rmap_pkg::*;
#(
  parameter int ARCH_N   = 8,
  parameter int PHYS_N   = 16,
  parameter int HAS_ZERO = 1,
  parameter int ZERO_IDX = 0,
  localparam int AW = $clog2(ARCH_N),
  localparam int PW = $clog2(PHYS_N),
  localparam int TW = PW + 2,
  localparam int CW = $clog2(PHYS_N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  input  logic [2:0]    ren_class,
  input  logic [AW-1:0] ren_arch,
  output logic          ren_ready,
  output logic [TW-1:0] ren_new_tag,
  output logic [TW-1:0] ren_prev_tag,
  output logic          ren_err,
  input  logic [2:0]    lk_class,
  input  logic [AW-1:0] lk_arch,
  output logic [TW-1:0] lk_tag,
  output logic          lk_err,
  input  logic          set_valid,
  input  logic [2:0]    set_class,
  input  logic [AW-1:0] set_arch,
  input  logic [TW-1:0] set_tag,
  output logic          set_err,
  input  logic          rel_valid,
  input  logic [TW-1:0] rel_tag,
  output logic [CW-1:0] free_cnt_int,
  output logic [CW-1:0] free_cnt_fp,
  output logic [CW-1:0] free_cnt_cc
);
  logic [PW-1:0] head  [4];
  logic [CW-1:0] cnt   [4];
  logic [PW-1:0] rd_rn [4];
  logic [PW-1:0] rd_lk [4];

  logic       ren_known, ren_misc, lk_known, lk_misc, set_known;
  logic       zero_ren, zero_set;
  logic [1:0] rsel, lsel, set_tcls, rel_tcls;
  logic [TW-1:0] set_misc_id;

  assign rsel      = ren_class[1:0];
  assign lsel      = lk_class[1:0];
  assign set_tcls  = set_tag[TW-1:PW];
  assign rel_tcls  = rel_tag[TW-1:PW];
  assign ren_known = ren_class < 3'd3;
  assign ren_misc  = ren_class == RC_MISC;
  assign lk_known  = lk_class < 3'd3;
  assign lk_misc   = lk_class == RC_MISC;
  assign set_known = set_class < 3'd3;
  assign zero_ren  = (HAS_ZERO != 0) && (ren_class == RC_INT) && (ren_arch == AW'(ZERO_IDX));
  assign zero_set  = (HAS_ZERO != 0) && (set_class == RC_INT) && (set_arch == AW'(ZERO_IDX));
  assign set_misc_id = {2'b11, PW'(set_arch)};

  // per-class pool and table
  for (genvar c = 0; c < 4; c++) begin : g_cls
    if (c < 3) begin : g_live
      logic alloc, restore, release_hit;
      assign alloc       = ren_valid && ren_ready && (ren_class == 3'(c)) && !zero_ren;
      assign restore     = set_valid && (set_class == 3'(c)) && (set_tcls == 2'(c)) && !zero_set;
      assign release_hit = rel_valid && (rel_tcls == 2'(c));

      rmap_freelist #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N), .PW(PW), .CW(CW)) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop      (alloc),
        .push     (release_hit),
        .push_idx (rel_tag[PW-1:0]),
        .head_idx (head[c]),
        .count    (cnt[c])
      );

      rmap_map_table #(.ARCH_N(ARCH_N), .AW(AW), .PW(PW)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .wa_en   (alloc),
        .wa_arch (ren_arch),
        .wa_idx  (head[c]),
        .wb_en   (restore),
        .wb_arch (set_arch),
        .wb_idx  (set_tag[PW-1:0]),
        .ra_arch (ren_arch),
        .ra_idx  (rd_rn[c]),
        .rb_arch (lk_arch),
        .rb_idx  (rd_lk[c])
      );
    end else begin : g_fixed
      assign head[c]  = '0;
      assign cnt[c]   = '0;
      assign rd_rn[c] = '0;
      assign rd_lk[c] = '0;
    end
  end

  // rename response
  always_comb begin
    ren_ready    = 1'b1;
    ren_new_tag  = '0;
    ren_prev_tag = '0;
    ren_err      = ren_valid && !ren_known && !ren_misc;
    if (ren_known) begin
      ren_ready    = cnt[rsel] != '0;
      ren_prev_tag = {rsel, rd_rn[rsel]};
      ren_new_tag  = zero_ren ? {rsel, rd_rn[rsel]} : {rsel, head[rsel]};
    end else if (ren_misc) begin
      ren_new_tag  = {2'b11, PW'(ren_arch)};
      ren_prev_tag = {2'b11, PW'(ren_arch)};
    end
  end

  // lookup response
  always_comb begin
    lk_tag = '0;
    lk_err = !lk_known && !lk_misc;
    if (lk_known)     lk_tag = {lsel, rd_lk[lsel]};
    else if (lk_misc) lk_tag = {2'b11, PW'(lk_arch)};
  end

  // restore checking
  always_comb begin
    set_err = 1'b0;
    if (set_valid) begin
      if (set_known)                   set_err = set_tcls != set_class[1:0];
      else if (set_class == RC_MISC)   set_err = set_tag != set_misc_id;
      else                             set_err = 1'b1;
    end
  end

  assign free_cnt_int = cnt[0];
  assign free_cnt_fp  = cnt[1];
  assign free_cnt_cc  = cnt[2];
endmodule

// File: rtl/rmap_checker.sv
module rmap_checker #(
  parameter int ARCH_N   = 8,
  parameter int PHYS_N   = 16,
  parameter int HAS_ZERO = 1,
  parameter int ZERO_IDX = 0,
  localparam int AW = $clog2(ARCH_N),
  localparam int PW = $clog2(PHYS_N),
  localparam int TW = PW + 2,
  localparam int CW = $clog2(PHYS_N + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ren_valid,
  input logic [2:0]    ren_class,
  input logic [AW-1:0] ren_arch,
  input logic          ren_ready,
  input logic [TW-1:0] ren_new_tag,
  input logic [TW-1:0] ren_prev_tag,
  input logic          ren_err,
  input logic [2:0]    lk_class,
  input logic [AW-1:0] lk_arch,
  input logic [TW-1:0] lk_tag,
  input logic          lk_err,
  input logic          set_valid,
  input logic [2:0]    set_class,
  input logic [AW-1:0] set_arch,
  input logic [TW-1:0] set_tag,
  input logic          set_err,
  input logic          rel_valid,
  input logic [TW-1:0] rel_tag,
  input logic [CW-1:0] free_cnt_int,
  input logic [CW-1:0] free_cnt_fp,
  input logic [CW-1:0] free_cnt_cc
);
  logic int_rel, fp_rel;
  assign int_rel = rel_valid && (rel_tag[TW-1:PW] == 2'd0);
  assign fp_rel  = rel_valid && (rel_tag[TW-1:PW] == 2'd1);

  // R2: an accepted integer rename of a non-zero register takes one tag
  a_r2_alloc_takes_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_ready && ren_class == 3'd0 && ren_arch != AW'(ZERO_IDX) && !int_rel)
    |=> free_cnt_int == $past(free_cnt_int) - CW'(1));

  // R3: misc rename hands back one fixed tag in both slots
  a_r3_misc_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_class == 3'd3) |-> (ren_new_tag == ren_prev_tag && !ren_err
      && ren_new_tag[TW-1:PW] == 2'd3));

  // R3: misc rename leaves all pools alone
  a_r3_misc_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_class == 3'd3 && !rel_valid)
    |=> ($stable(free_cnt_int) && $stable(free_cnt_fp) && $stable(free_cnt_cc)));

  // R4: misc lookup is the identity tag
  a_r4_misc_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_class == 3'd3) |-> (lk_tag == {2'b11, PW'(lk_arch)} && !lk_err));

  // R6: restore with a foreign tag class is flagged
  a_r6_class_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (set_valid && set_class < 3'd3 && set_tag[TW-1:PW] != set_class[1:0]) |-> set_err);

  // R7: unknown codes flag every port
  a_r7_unknown_ren: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_class > 3'd3) |-> (ren_err && ren_new_tag == '0));
  a_r7_unknown_lk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_class > 3'd3) |-> (lk_err && lk_tag == '0));
  a_r7_unknown_set: assert property (@(posedge clk) disable iff (!rst_n)
    (set_valid && set_class > 3'd3) |-> set_err);

  // R8: zero register gets no new tag
  a_r8_zero_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_ZERO != 0 && ren_valid && ren_class == 3'd0 && ren_arch == AW'(ZERO_IDX) && !int_rel)
    |=> $stable(free_cnt_int));

  // R9: empty floating-point pool stalls and keeps its count
  a_r9_empty_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_class == 3'd1 && free_cnt_fp == '0) |-> !ren_ready);
  a_r9_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_class == 3'd1 && free_cnt_fp == '0 && !fp_rel) |=> free_cnt_fp == '0);
endmodule

bind rmap_top rmap_checker #(
  .ARCH_N(ARCH_N), .PHYS_N(PHYS_N), .HAS_ZERO(HAS_ZERO), .ZERO_IDX(ZERO_IDX)
) u_chk (.*);

// File: tb/sim_rmap_top.sv
module sim_rmap_top;
  localparam int ARCH_N = 8;
  localparam int PHYS_N = 16;
  localparam int AW = $clog2(ARCH_N);
  localparam int PW = $clog2(PHYS_N);
  localparam int TW = PW + 2;
  localparam int CW = $clog2(PHYS_N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ren_valid = 1'b0, set_valid = 1'b0, rel_valid = 1'b0;
  logic [2:0] ren_class = '0, lk_class = '0, set_class = '0;
  logic [AW-1:0] ren_arch = '0, lk_arch = '0, set_arch = '0;
  logic [TW-1:0] set_tag = '0, rel_tag = '0;
  logic ren_ready, ren_err, lk_err, set_err;
  logic [TW-1:0] ren_new_tag, ren_prev_tag, lk_tag;
  logic [CW-1:0] free_cnt_int, free_cnt_fp, free_cnt_cc;

  always #4 clk = ~clk;

  rmap_top u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  int mmap [3][ARCH_N];
  int pool [3][$];
  int dead [$];

  function automatic int tg(int c, int i);
    return c * PHYS_N + i;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 3; c++) begin
      pool[c].delete();
      for (int i = 0; i < ARCH_N; i++) mmap[c][i] = i;
      for (int i = ARCH_N; i < PHYS_N; i++) pool[c].push_back(i);
    end
    dead.delete();
  endtask

  // compare every output against the model, then advance one clock
  task automatic step(string req);
    int rc, ra, lc, la, sc, sa, st, exp_rdy, exp_new, exp_prev, exp_lk, exp_serr;
    bit zr, zs;
    #2;
    rc = int'(ren_class); ra = int'(ren_arch);
    lc = int'(lk_class);  la = int'(lk_arch);
    sc = int'(set_class); sa = int'(set_arch); st = int'(set_tag);
    zr = (rc == 0 && ra == 0);
    zs = (sc == 0 && sa == 0);
    exp_rdy = 1; exp_new = 0; exp_prev = 0;
    if (rc < 3) begin
      exp_rdy  = pool[rc].size() != 0;
      exp_prev = tg(rc, mmap[rc][ra]);
      exp_new  = zr ? exp_prev : (exp_rdy ? tg(rc, pool[rc][0]) : int'(ren_new_tag));
    end else if (rc == 3) begin
      exp_new = tg(3, ra); exp_prev = exp_new;
    end
    exp_lk = (lc < 3) ? tg(lc, mmap[lc][la]) : (lc == 3 ? tg(3, la) : 0);
    exp_serr = 0;
    if (set_valid) begin
      if (sc < 3) exp_serr = (st / PHYS_N) != sc;
      else if (sc == 3) exp_serr = st != tg(3, sa);
      else exp_serr = 1;
    end
    chk(req, "ren_ready", int'(ren_ready), exp_rdy);
    chk(req, "ren_new_tag", int'(ren_new_tag), exp_new);
    chk(req, "ren_prev_tag", int'(ren_prev_tag), exp_prev);
    chk(req, "ren_err", int'(ren_err), int'(ren_valid) & int'(rc > 3));
    chk(req, "lk_tag", int'(lk_tag), exp_lk);
    chk(req, "lk_err", int'(lk_err), int'(lc > 3));
    chk(req, "set_err", int'(set_err), exp_serr);
    chk(req, "free_cnt_int", int'(free_cnt_int), pool[0].size());
    chk(req, "free_cnt_fp", int'(free_cnt_fp), pool[1].size());
    chk(req, "free_cnt_cc", int'(free_cnt_cc), pool[2].size());
    @(posedge clk);
    if (ren_valid && rc < 3 && exp_rdy && !zr) begin
      mmap[rc][ra] = pool[rc].pop_front();
      dead.push_back(exp_prev);
    end
    if (set_valid && sc < 3 && (st / PHYS_N) == sc && !zs) mmap[sc][sa] = st % PHYS_N;
    if (rel_valid && (int'(rel_tag) / PHYS_N) < 3)
      pool[int'(rel_tag) / PHYS_N].push_back(int'(rel_tag) % PHYS_N);
    @(negedge clk);
  endtask

  task automatic idle();
    ren_valid = 0; set_valid = 0; rel_valid = 0;
  endtask

  task automatic ren(int c, int a);
    ren_valid = 1; ren_class = 3'(c); ren_arch = AW'(a);
  endtask

  task automatic setq(int c, int a, int t);
    set_valid = 1; set_class = 3'(c); set_arch = AW'(a); set_tag = TW'(t);
  endtask

  task automatic look(int c, int a);
    lk_class = 3'(c); lk_arch = AW'(a);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset map, pool contents and counts
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < ARCH_N; a++) begin idle(); look(c, a); step("R1"); end
    // R2 integer rename, then R12 lookup shows it next cycle
    ren(0, 3); look(0, 3); step("R2");
    idle(); look(0, 3); step("R12");
    ren(2, 7); step("R2");
    // R3 misc rename, R4 misc lookup
    ren(3, 5); look(3, 6); step("R3");
    idle(); look(3, 2); step("R4");
    // R5 misc restore: matching, then mismatched
    setq(3, 4, tg(3, 4)); step("R5");
    setq(3, 4, tg(3, 1)); look(3, 4); step("R5");
    // R6 restore with wrong class, then a legal one
    setq(0, 3, tg(1, 2)); look(0, 3); step("R6");
    idle(); look(0, 3); step("R6");
    setq(0, 3, tg(0, 3)); step("R6");
    idle(); look(0, 3); step("R6");
    // R7 unknown class codes on every port
    ren(5, 1); look(6, 1); setq(7, 1, tg(0, 1)); step("R7");
    idle(); look(4, 0); step("R7");
    // R8 zero register
    ren(0, 0); step("R8");
    setq(0, 0, tg(0, 9)); look(0, 0); step("R8");
    idle(); look(0, 0); step("R8");
    // R9 drain floating-point pool, then stall
    for (int k = 0; k < PHYS_N - ARCH_N; k++) begin idle(); ren(1, k % ARCH_N); step("R9"); end
    idle(); ren(1, 2); look(1, 2); step("R9");
    idle(); ren(1, 2); look(1, 2); step("R9");
    // R10 release to empty pool, then misc release ignored
    idle(); rel_valid = 1; rel_tag = TW'(tg(1, 3)); step("R10");
    idle(); ren(1, 6); step("R10");
    idle(); rel_valid = 1; rel_tag = TW'(tg(3, 3)); step("R10");
    // R10 rename and release in one pool in one cycle
    idle(); ren(2, 1); rel_valid = 1; rel_tag = TW'(tg(2, 7)); step("R10");
    // R11 rename and restore to the same entry
    idle(); ren(0, 5); setq(0, 5, tg(0, 5)); step("R11");
    idle(); look(0, 5); step("R11");
    // random mix, also checks R2 against the model every cycle
    dead.delete();
    for (int n = 0; n < 1500; n++) begin
      int c, sc;
      idle();
      c = ($urandom_range(0, 19) == 0) ? $urandom_range(4, 7) : $urandom_range(0, 3);
      if ($urandom_range(0, 3) != 0) ren(c, $urandom_range(0, ARCH_N - 1));
      look($urandom_range(0, 4), $urandom_range(0, ARCH_N - 1));
      if ($urandom_range(0, 5) == 0) begin
        sc = $urandom_range(0, 3);
        setq(sc, $urandom_range(0, ARCH_N - 1),
             (sc < 3) ? tg($urandom_range(0, 3) == 0 ? $urandom_range(0, 3) : sc,
                           $urandom_range(0, PHYS_N - 1))
                      : tg(3, $urandom_range(0, ARCH_N - 1)));
      end
      if (dead.size() != 0 && $urandom_range(0, 2) != 0) begin
        int t;
        t = dead[0];
        if (pool[t / PHYS_N].size() < PHYS_N - 1) begin
          void'(dead.pop_front());
          rel_valid = 1; rel_tag = TW'(t);
        end
      end
      step("R2");
    end
    idle();
    step("R12");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule